// File: doc/BRIEF.md
# Drowsy Line Controller

This block governs the low-leakage retention mode for every line of a small cache data array. Each line owns one status bit that chooses its supply: the full-voltage rail when clear, the low retention rail when set. A free-running timer raises a sleep pulse once per period, and that pulse sets the status bit of every line in the same cycle. A line in retention keeps its contents, but its word line is gated, so the stored word cannot be read or written until the line is brought back to full voltage.

A request names a line, a direction and, for writes, a data word. If the line is already at full voltage, the access completes with the normal one-cycle latency. If the line is in retention, the controller first clears that line's status bit, which is the wake-up. It then raises a stall output for a fixed, parameterised number of cycles, and finally serves the request from the retained contents. No refetch and no writeback are involved. The analog regulators and the SRAM cells are not modelled; the block drives only the per-line rail selects and the gated storage it fronts.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, every rail select goes to 0 (full voltage), `rsp_valid` and `rsp_stall` are 0, and every stored word is cleared to zero.
- R2: The sleep pulse occurs every `PERIOD` clock edges. The first one lands on the `PERIOD`-th edge after reset is released. It sets all `rail_low` bits together, except a line being woken in that cycle.
- R3: A request accepted for a line whose `rail_low` bit is 0 raises no stall. `rsp_valid` is 1 in the cycle after acceptance, and for a read `rsp_rdata` carries the stored word.
- R4: A request accepted for a line whose `rail_low` bit is 1 holds `rsp_stall` high for exactly `WAKE_CYC` cycles, starting in the cycle after acceptance. `rsp_valid` is 1 in the cycle right after the stall drops. Storage is never accessed while the addressed line is on the low rail.
- R5: A wake-up clears only the addressed line's `rail_low` bit. All other lines stay on the low rail.
- R6: A word written before a sleep pulse is returned unchanged by a read after the line has been woken.
- R7: `req_valid` is ignored while `rsp_stall` is 1. A request presented then performs no write and wakes no line.
- R8: When an access is accepted, or a wake-up is pending, in the same cycle as a sleep pulse, the accessed line stays at full voltage while every other line goes to the low rail.
- R9: A write also produces a one-cycle `rsp_valid`, and `rsp_rdata` then shows the word just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `rsp_stall` is 0 |
| req_idx | input | IDX_W | Line index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse when a request completes |
| rsp_rdata | output | DATA_W | Read data, or the written word for a write |
| rsp_stall | output | 1 | High while a line is waking; requests are ignored |
| rail_low | output | LINES | Per-line supply select, 1 = low retention rail |

## Verification
The bench lands a request exactly on the sleep-pulse edge. A design that let the pulse win would leave the accessed line on the low rail. It also lets a pulse fall inside a multi-cycle wake-up, which catches a design that clears the bit only once and lets the line re-enter retention before it is served. During a stall it presents a conflicting write to another line. A design that accepted it would either corrupt that line or wake it. Finally, it counts the stall cycles and checks the data after retention, which exposes an off-by-one in the wake counter or a contents loss that a refetch-style design would cause.

// File: rtl/dlc_pkg.sv
// Package: shared types of the drowsy line controller.
// Assumes nothing beyond IEEE 1800-2017.
package dlc_pkg;

    // Request sequencer states: ready for a new request, or waking a line.
    typedef enum logic [0:0] {
        SEQ_READY = 1'b0,
        SEQ_WAKE  = 1'b1
    } dlc_seq_e;

endpackage

// File: rtl/dlc_period_timer.sv
// Module: dlc_period_timer
// Emits a one-cycle sleep pulse every PERIOD clock cycles.
// Assumes PERIOD >= 2. The counter restarts from zero on reset.
module dlc_period_timer #(
    parameter int PERIOD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic sleep_pulse
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] tick_q;

    // Count cycles modulo PERIOD.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (tick_q == CW'(PERIOD - 1))
            tick_q <= '0;
        else
            tick_q <= tick_q + 1'b1;
    end

    // Pulse in the last cycle of each period; lines change on the next edge.
    always_comb sleep_pulse = (tick_q == CW'(PERIOD - 1));

endmodule

// File: rtl/dlc_drowsy_bits.sv
// Module: dlc_drowsy_bits
// Holds one retention bit per line. Reset clears all bits.
// A wake request for a line overrides a simultaneous sleep pulse for that line.
// Assumes wake_idx is below LINES.
module dlc_drowsy_bits #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_all,
    input  logic             wake_en,
    input  logic [IDX_W-1:0] wake_idx,
    output logic [LINES-1:0] drowsy
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic wake_me;

            // Decode whether this line is being woken.
            always_comb wake_me = wake_en && (wake_idx == IDX_W'(g));

            // Update the retention bit: reset, then wake, then sleep.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    drowsy[g] <= 1'b0;
                else if (wake_me)
                    drowsy[g] <= 1'b0;
                else if (sleep_all)
                    drowsy[g] <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/dlc_line_store.sv
// Module: dlc_line_store
// Word storage for the lines, with word-line gating.
// An access only reaches the cells when the addressed line is at full voltage.
// Assumes one access per cycle. Contents are cleared on reset.
module dlc_line_store #(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [LINES-1:0]  line_drowsy,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [LINES];
    logic              wl_open;

    // Open the word line only for an awake line.
    always_comb wl_open = acc_en && !line_drowsy[acc_idx];

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_row
            // Write one row when its gated word line is open.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cells[g] <= '0;
                else if (wl_open && acc_wr && (acc_idx == IDX_W'(g)))
                    cells[g] <= acc_wdata;
            end
        end
    endgenerate

    // Read through the gated word line; a closed line reads as zero.
    always_comb rd_data = wl_open ? cells[acc_idx] : '0;

endmodule

// File: rtl/drowsy_line_ctrl.sv
// Module: drowsy_line_ctrl (top)
// Sequences requests against per-line retention bits. An awake line is served
// at once. A line in retention is woken, stalls for WAKE_CYC cycles, and is
// then served. A periodic pulse puts all lines into retention.
// Assumes LINES is a power of two and WAKE_CYC >= 1.
module drowsy_line_ctrl
    import dlc_pkg::*;
#(
    parameter int LINES    = 16,
    parameter int DATA_W   = 32,
    parameter int WAKE_CYC = 1,
    parameter int PERIOD   = 4096,
    parameter int IDX_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_stall,
    output logic [LINES-1:0]  rail_low
);
    localparam int WCW = $clog2(WAKE_CYC + 1);

    dlc_seq_e          seq_q;
    logic [WCW-1:0]    wcnt_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic              pend_wr_q;
    logic [DATA_W-1:0] pend_wdata_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic              sleep_pulse;
    logic [LINES-1:0]  drowsy;
    logic              accept;
    logic              wake_done;
    logic              acc_en;
    logic              acc_wr;
    logic [IDX_W-1:0]  acc_idx;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] rd_data;
    logic              wake_en;

    // Accept a request only when no wake-up is in progress.
    always_comb accept = req_valid && (seq_q == SEQ_READY);

    // The wake-up is finished in its last stall cycle.
    always_comb wake_done = (seq_q == SEQ_WAKE) && (wcnt_q == '0);

    // Choose the access source: a pending woken request or the port.
    always_comb begin
        if (seq_q == SEQ_WAKE) begin
            acc_en    = wake_done;
            acc_wr    = pend_wr_q;
            acc_idx   = pend_idx_q;
            acc_wdata = pend_wdata_q;
        end else begin
            acc_en    = accept && !drowsy[req_idx];
            acc_wr    = req_write;
            acc_idx   = req_idx;
            acc_wdata = req_wdata;
        end
    end

    // Keep the accessed or pending line awake against a sleep pulse.
    always_comb wake_en = accept || (seq_q == SEQ_WAKE);

    dlc_period_timer #(
        .PERIOD(PERIOD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_pulse(sleep_pulse)
    );

    dlc_drowsy_bits #(
        .LINES(LINES),
        .IDX_W(IDX_W)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_all(sleep_pulse),
        .wake_en  (wake_en),
        .wake_idx (acc_idx),
        .drowsy   (drowsy)
    );

    dlc_line_store #(
        .LINES (LINES),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .acc_idx    (acc_idx),
        .acc_wdata  (acc_wdata),
        .line_drowsy(drowsy),
        .rd_data    (rd_data)
    );

    // Sequencer: enter wake-up for a line in retention, count the stall down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SEQ_READY;
            wcnt_q <= '0;
        end else if (seq_q == SEQ_READY) begin
            if (accept && drowsy[req_idx]) begin
                seq_q  <= SEQ_WAKE;
                wcnt_q <= WCW'(WAKE_CYC - 1);
            end
        end else if (wake_done) begin
            seq_q <= SEQ_READY;
        end else begin
            wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // Capture the request that has to wait for its line to wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx_q   <= '0;
            pend_wr_q    <= 1'b0;
            pend_wdata_q <= '0;
        end else if (accept) begin
            pend_idx_q   <= req_idx;
            pend_wr_q    <= req_write;
            pend_wdata_q <= req_wdata;
        end
    end

    // Register the response of each completed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= acc_en;
            if (acc_en)
                rsp_rdata_q <= acc_wr ? acc_wdata : rd_data;
        end
    end

    // Drive the outputs.
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_rdata_q;
        rsp_stall = (seq_q == SEQ_WAKE);
        rail_low  = drowsy;
    end

endmodule

// File: rtl/drowsy_line_ctrl_chk.sv
// Module: drowsy_line_ctrl_chk
// Protocol and timing properties of drowsy_line_ctrl, attached by bind.
// Assumes the bench starts with rst_n low.
module drowsy_line_ctrl_chk #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_valid,
    input logic             rsp_stall,
    input logic [LINES-1:0] rail_low,
    input logic             acc_en,
    input logic [IDX_W-1:0] acc_idx
);
    // R1: reset leaves all lines awake and no response pending.
    assert_reset_awake_R1: assert property (@(posedge clk)
        !rst_n |=> (rail_low == '0 && !rsp_valid && !rsp_stall));

    // R3: an awake line is served next cycle without stall.
    assert_awake_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_stall && !rail_low[req_idx]) |=> (rsp_valid && !rsp_stall));

    // R4: a line in retention causes a stall next cycle.
    assert_drowsy_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_stall && rail_low[req_idx]) |=> (rsp_stall && !rsp_valid));

    // R4: the response follows the end of the stall.
    assert_stall_end_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_stall) |-> rsp_valid);

    // R4: storage is never reached through a gated word line.
    assert_gated_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> !rail_low[acc_idx]);

    // R8: the line of an accepted request is awake afterwards.
    assert_access_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_stall) |=> !rail_low[$past(req_idx)]);

endmodule

bind drowsy_line_ctrl drowsy_line_ctrl_chk #(
    .LINES(LINES),
    .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_idx  (req_idx),
    .rsp_valid(rsp_valid),
    .rsp_stall(rsp_stall),
    .rail_low (rail_low),
    .acc_en   (acc_en),
    .acc_idx  (acc_idx)
);

// File: tb/drowsy_line_ctrl_tb.sv
// Bench: directed scenarios, one task each, for drowsy_line_ctrl.
module drowsy_line_ctrl_tb;
    localparam int LINES  = 8;
    localparam int DATA_W = 16;
    localparam int WAKE   = 3;
    localparam int PER    = 64;
    localparam int IDX_W  = $clog2(LINES);
    localparam logic [LINES-1:0] ALL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [IDX_W-1:0]  req_idx = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_stall;
    logic [LINES-1:0]  rail_low;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    drowsy_line_ctrl #(
        .LINES(LINES), .DATA_W(DATA_W), .WAKE_CYC(WAKE), .PERIOD(PER)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall), .rail_low(rail_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Hold reset, check reset state, release on a falling edge.
    task automatic reset_dut();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rail_low", 32'(rail_low), 32'(0));
        chk("R1 valid/stall", {30'd0, rsp_valid, rsp_stall}, 32'd0);
        rst_n = 1'b1;
    endtask

    // One request; returns stall cycles, response valid and data.
    task automatic do_op(input int idx, input bit wr, input logic [DATA_W-1:0] d,
                         output int stalls, output bit vld, output logic [DATA_W-1:0] rd);
        req_valid = 1'b1;
        req_idx = IDX_W'(idx);
        req_write = wr;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        stalls = 0;
        while (rsp_stall && stalls < 100) begin
            stalls++;
            @(negedge clk);
        end
        vld = rsp_valid;
        rd = rsp_rdata;
    endtask

    task automatic t_reset();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        do_op(0, 1'b0, '0, s, v, r);
        chk("R1 read after reset data", 32'(r), 32'(0));
        chk("R3 no stall after reset", 32'(s), 32'(0));
    endtask

    task automatic t_awake();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        for (int i = 0; i < LINES; i++) begin
            do_op(i, 1'b1, DATA_W'(16'hA500 + i * 3), s, v, r);
            chk("R9 write echo", 32'(r), 32'(16'hA500 + i * 3));
            chk("R9 write valid", {31'd0, v}, 32'd1);
        end
        for (int i = LINES - 1; i >= 0; i--) begin
            do_op(i, 1'b0, '0, s, v, r);
            chk("R3 read data", 32'(r), 32'(16'hA500 + i * 3));
            chk("R3 no stall", 32'(s), 32'(0));
        end
    endtask

    task automatic t_period();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        repeat (PER - 1) @(negedge clk);
        chk("R2 before first pulse", 32'(rail_low), 32'(0));
        @(negedge clk);
        chk("R2 first pulse", 32'(rail_low), 32'(ALL));
        do_op(2, 1'b0, '0, s, v, r);
        chk("R5 only line 2 woken", 32'(rail_low), 32'(ALL & ~(LINES'(1) << 2)));
        repeat (PER - 5) @(negedge clk);
        chk("R2 before second pulse", 32'(rail_low), 32'(ALL & ~(LINES'(1) << 2)));
        @(negedge clk);
        chk("R2 second pulse", 32'(rail_low), 32'(ALL));
    endtask

    task automatic t_drowsy();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        do_op(1, 1'b1, 16'h1234, s, v, r);
        do_op(5, 1'b1, 16'hBEEF, s, v, r);
        repeat (PER - 2) @(negedge clk);
        chk("R2 all drowsy", 32'(rail_low), 32'(ALL));
        do_op(5, 1'b0, '0, s, v, r);
        chk("R4 stall cycles", 32'(s), 32'(WAKE));
        chk("R4 valid after stall", {31'd0, v}, 32'd1);
        chk("R6 retained data line 5", 32'(r), 32'(16'hBEEF));
        chk("R5 wake only line 5", 32'(rail_low), 32'(ALL & ~(LINES'(1) << 5)));
        do_op(5, 1'b0, '0, s, v, r);
        chk("R3 woken line fast", 32'(s), 32'(0));
        do_op(1, 1'b0, '0, s, v, r);
        chk("R6 retained data line 1", 32'(r), 32'(16'h1234));
        chk("R4 stall cycles line 1", 32'(s), 32'(WAKE));
    endtask

    task automatic t_ignore();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        do_op(3, 1'b1, 16'h0C0C, s, v, r);
        repeat (PER - 1) @(negedge clk);
        req_valid = 1'b1; req_idx = 3'd3; req_write = 1'b0;
        @(negedge clk);
        req_idx = 3'd4; req_write = 1'b1; req_wdata = 16'hDEAD;
        s = 0;
        while (rsp_stall && s < 100) begin
            s++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R7 read during stall data", 32'(rsp_rdata), 32'(16'h0C0C));
        chk("R7 line 4 not woken", {31'd0, rail_low[4]}, 32'd1);
        do_op(4, 1'b0, '0, s, v, r);
        chk("R7 line 4 not written", 32'(r), 32'(0));
    endtask

    task automatic t_collide();
        int s; bit v; logic [DATA_W-1:0] r;
        reset_dut();
        repeat (PER - 1) @(negedge clk);
        do_op(6, 1'b0, '0, s, v, r);
        chk("R8 access on pulse no stall", 32'(s), 32'(0));
        chk("R8 accessed line stays awake", 32'(rail_low), 32'(ALL & ~(LINES'(1) << 6)));
        repeat (PER - 2) @(negedge clk);
        do_op(0, 1'b0, '0, s, v, r);
        chk("R8 pulse inside wake stall", 32'(s), 32'(WAKE));
        chk("R8 woken line survives pulse", 32'(rail_low), 32'(ALL & ~LINES'(1)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_awake();
        t_period();
        t_drowsy();
        t_ignore();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule